// File: doc/BRIEF.md
# Debug Halt Request Controller

This block decides when a processor core must stop for background debug and records which source stopped it. Three sources can stop the core. The first is a fault-on-fault condition, which stops the core at once. The second is a hardware breakpoint trigger, which is held as a pending request and taken only at an instruction-boundary sample strobe. The third is a decoded HALT instruction.

A HALT instruction executed in user mode is allowed only when the user-halt-enable control bit is set. Otherwise the block requests a privilege-violation exception and the core keeps running.

While the core is halted, a GO command from the serial debug port releases it. The block then gives a one-cycle resume pulse, which tells the core to continue at the instruction after the one that halted it. All outputs are registered, and reset is synchronous and active-high.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: Synchronous reset, at any time, drives halted_o to 0, cause_o to 2'b00, priv_viol_o to 0 and resume_o to 0, and discards any pending breakpoint request.
- R2: With the core running, fault_i high causes halted_o to be 1 with cause_o = 2'b01 after the next clock edge, whatever the state of sample_i.
- R3: With the core running, bkpt_i high stores a pending request. The halt (cause_o = 2'b10) is taken at the first clock edge where sample_i is high, counting only cycles after the cycle in which bkpt_i was high. A strobe in the same cycle as bkpt_i does not take it. The request stays pending across cycles without a strobe.
- R4: The pending breakpoint request is cleared when any halt is entered. This includes a breakpoint that arrives in the same cycle as the halt entry. After the following GO, a sample strobe alone does not halt the core.
- R5: With the core running, halt_insn_i high causes halted_o to be 1 with cause_o = 2'b11 after the next clock edge, with no sample strobe needed. This holds when user_mode_i is 0, or when user_mode_i is 1 and user_halt_en_i is 1.
- R6: halt_insn_i high with user_mode_i = 1 and user_halt_en_i = 0 does not halt the core. Instead it drives priv_viol_o high for exactly one cycle after the next clock edge.
- R7: Sources that are active together are ranked fault (2'b01) over a breakpoint being taken (2'b10) over a HALT instruction (2'b11). No privilege violation is raised when a higher source halts the core in the same cycle.
- R8: go_i high while halted clears halted_o and sets cause_o to 2'b00 after the next clock edge. It also drives resume_o high for exactly one cycle.
- R9: go_i high while the core is running has no effect: resume_o stays 0 and halted_o stays 0.
- R10: While halted, fault_i, halt_insn_i and bkpt_i have no effect. cause_o is held, and a breakpoint seen while halted is not left pending after the GO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 1 | Fault-on-fault indication |
| bkpt_i | input | 1 | Hardware breakpoint trigger |
| halt_insn_i | input | 1 | HALT instruction decoded and executing |
| user_mode_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| user_halt_en_i | input | 1 | Permits HALT in user mode when 1 |
| sample_i | input | 1 | Instruction-boundary sample strobe |
| go_i | input | 1 | GO command from the serial debug port |
| halted_o | output | 1 | Core is halted for debug |
| cause_o | output | 2 | Halt cause: 00 none, 01 fault, 10 breakpoint, 11 HALT instruction |
| priv_viol_o | output | 1 | One-cycle privilege-violation exception request |
| resume_o | output | 1 | One-cycle pulse: continue after the halting instruction |

## Verification
The pending-breakpoint flag is the only state that is not visible at the ports. A wrong value there shows up only at the next sample strobe. If the flag is stuck, a strobe halts the core with cause 2'b10 when it should not. If it is lost, a strobe that should halt the core does nothing. The bench therefore follows every breakpoint scenario, including breakpoints seen during a halt or at halt entry, with a lone strobe after the GO. A wrong halted or cause register is visible one cycle after the input that should have set it, so every vector is checked in the cycle right after its clock edge.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CAUSE_W = 2;
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_FAULT = 2'b01,
    CAUSE_BKPT  = 2'b10,
    CAUSE_HALTI = 2'b11
  } halt_cause_e;
endpackage

// File: rtl/dbg_bkpt_pend.sv
module dbg_bkpt_pend (
  input  logic clk,
  input  logic rst,
  input  logic bkpt_i,
  input  logic halted_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  // Entering a halt always wins over a new trigger.
  always_ff @(posedge clk) begin
    if (rst)                      pend_q <= 1'b0;
    else if (take_i)              pend_q <= 1'b0;
    else if (bkpt_i && !halted_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  p_pend_set_r3: assert property (@(posedge clk) disable iff (rst)
    (bkpt_i && !halted_i && !take_i) |=> pend_q);
  p_pend_clr_r4: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !pend_q);
endmodule

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb
  import dbg_halt_pkg::*;
(
  input  logic        halted_i,
  input  logic        fault_i,
  input  logic        pend_i,
  input  logic        sample_i,
  input  logic        halt_insn_i,
  input  logic        user_mode_i,
  input  logic        user_halt_en_i,
  output logic        take_o,
  output halt_cause_e cause_o,
  output logic        priv_viol_o
);
  logic insn_blocked;

  assign insn_blocked = user_mode_i && !user_halt_en_i;

  always_comb begin
    take_o      = 1'b0;
    cause_o     = CAUSE_NONE;
    priv_viol_o = 1'b0;
    if (!halted_i) begin
      if (fault_i) begin
        take_o  = 1'b1;
        cause_o = CAUSE_FAULT;
      end else if (pend_i && sample_i) begin
        take_o  = 1'b1;
        cause_o = CAUSE_BKPT;
      end else if (halt_insn_i) begin
        if (insn_blocked) begin
          priv_viol_o = 1'b1;
        end else begin
          take_o  = 1'b1;
          cause_o = CAUSE_HALTI;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_halt_state.sv
module dbg_halt_state
  import dbg_halt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take_i,
  input  halt_cause_e cause_i,
  input  logic        priv_viol_i,
  input  logic        go_i,
  output logic        halted_o,
  output halt_cause_e cause_o,
  output logic        priv_viol_o,
  output logic        resume_o
);
  logic        halted_q;
  halt_cause_e cause_q;
  logic        pv_q;
  logic        res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      pv_q     <= 1'b0;
      res_q    <= 1'b0;
    end else begin
      pv_q  <= priv_viol_i;
      res_q <= 1'b0;
      if (halted_q) begin
        if (go_i) begin
          halted_q <= 1'b0;
          cause_q  <= CAUSE_NONE;
          res_q    <= 1'b1;
        end
      end else if (take_i) begin
        halted_q <= 1'b1;
        cause_q  <= cause_i;
      end
    end
  end

  assign halted_o    = halted_q;
  assign cause_o     = cause_q;
  assign priv_viol_o = pv_q;
  assign resume_o    = res_q;

  p_resume_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    res_q |=> !res_q);
  p_pv_no_halt_r6: assert property (@(posedge clk) disable iff (rst)
    pv_q |-> !halted_q);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fault_i,
  input  logic       bkpt_i,
  input  logic       halt_insn_i,
  input  logic       user_mode_i,
  input  logic       user_halt_en_i,
  input  logic       sample_i,
  input  logic       go_i,
  output logic       halted_o,
  output logic [1:0] cause_o,
  output logic       priv_viol_o,
  output logic       resume_o
);
  logic        pend;
  logic        take;
  logic        pv_next;
  halt_cause_e cause_next;
  halt_cause_e cause_q;

  dbg_bkpt_pend u_pend (
    .clk      (clk),
    .rst      (rst),
    .bkpt_i   (bkpt_i),
    .halted_i (halted_o),
    .take_i   (take),
    .pend_o   (pend)
  );

  dbg_halt_arb u_arb (
    .halted_i       (halted_o),
    .fault_i        (fault_i),
    .pend_i         (pend),
    .sample_i       (sample_i),
    .halt_insn_i    (halt_insn_i),
    .user_mode_i    (user_mode_i),
    .user_halt_en_i (user_halt_en_i),
    .take_o         (take),
    .cause_o        (cause_next),
    .priv_viol_o    (pv_next)
  );

  dbg_halt_state u_state (
    .clk         (clk),
    .rst         (rst),
    .take_i      (take),
    .cause_i     (cause_next),
    .priv_viol_i (pv_next),
    .go_i        (go_i),
    .halted_o    (halted_o),
    .cause_o     (cause_q),
    .priv_viol_o (priv_viol_o),
    .resume_o    (resume_o)
  );

  assign cause_o = cause_q;

  p_fault_halt_r2: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && fault_i) |=> (halted_o && cause_o == 2'b01));
  p_bkpt_at_sample_r3: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && !fault_i && pend && sample_i) |=> (halted_o && cause_o == 2'b10));
  p_privviol_r6: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && !fault_i && !(pend && sample_i) && halt_insn_i && user_mode_i && !user_halt_en_i)
      |=> (priv_viol_o && !halted_o));
  p_go_resume_r8: assert property (@(posedge clk) disable iff (rst)
    (halted_o && go_i) |=> (!halted_o && resume_o && cause_o == 2'b00));
  p_go_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && go_i) |=> !resume_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !go_i) |=> (halted_o && $stable(cause_o)));
  p_cause_match_r7: assert property (@(posedge clk) disable iff (rst)
    halted_o == (cause_o != 2'b00));
endmodule

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fault_i = 0, bkpt_i = 0, halt_insn_i = 0, user_mode_i = 0;
  logic user_halt_en_i = 0, sample_i = 0, go_i = 0;
  logic       halted_o;
  logic [1:0] cause_o;
  logic       priv_viol_o;
  logic       resume_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  dbg_halt_ctrl uut (
    .clk(clk), .rst(rst), .fault_i(fault_i), .bkpt_i(bkpt_i),
    .halt_insn_i(halt_insn_i), .user_mode_i(user_mode_i),
    .user_halt_en_i(user_halt_en_i), .sample_i(sample_i), .go_i(go_i),
    .halted_o(halted_o), .cause_o(cause_o), .priv_viol_o(priv_viol_o),
    .resume_o(resume_o)
  );

  // [15:12] requirement, [11:5] {fault,bkpt,halt_insn,user,uhe,sample,go},
  // [4:0] expected {halted,cause[1:0],priv_viol,resume}
  localparam int NV = 27;
  localparam logic [15:0] VEC [NV] = '{
    {4'd1,  7'b0000000, 5'b00000}, // R1 idle
    {4'd2,  7'b1000000, 5'b10100}, // R2 fault halts
    {4'd8,  7'b0000001, 5'b00001}, // R8 go
    {4'd8,  7'b0000000, 5'b00000}, // R8 pulse ends
    {4'd9,  7'b0000001, 5'b00000}, // R9 go while running
    {4'd3,  7'b0100010, 5'b00000}, // R3 strobe with trigger not taken
    {4'd3,  7'b0000000, 5'b00000}, // R3 pending, no strobe
    {4'd3,  7'b0000010, 5'b11000}, // R3 taken at strobe
    {4'd8,  7'b0000001, 5'b00001},
    {4'd4,  7'b0000010, 5'b00000}, // R4 pending cleared
    {4'd5,  7'b0010000, 5'b11100}, // R5 supervisor HALT
    {4'd8,  7'b0000001, 5'b00001},
    {4'd5,  7'b0011100, 5'b11100}, // R5 user HALT enabled
    {4'd8,  7'b0000001, 5'b00001},
    {4'd6,  7'b0011000, 5'b00010}, // R6 user HALT blocked
    {4'd6,  7'b0000000, 5'b00000}, // R6 one-cycle pulse
    {4'd7,  7'b1011000, 5'b10100}, // R7 fault over blocked HALT
    {4'd10, 7'b1010000, 5'b10100}, // R10 fault and HALT while halted
    {4'd10, 7'b0100000, 5'b10100}, // R10 trigger while halted
    {4'd8,  7'b0000001, 5'b00001},
    {4'd10, 7'b0000010, 5'b00000}, // R10 no stale pending
    {4'd3,  7'b0100000, 5'b00000}, // R3 arm
    {4'd7,  7'b0010010, 5'b11000}, // R7 breakpoint over HALT
    {4'd8,  7'b0000001, 5'b00001},
    {4'd7,  7'b1100000, 5'b10100}, // R7 fault with trigger
    {4'd8,  7'b0000001, 5'b00001},
    {4'd4,  7'b0000010, 5'b00000}  // R4 trigger at halt entry dropped
  };

  task automatic check(input int req, input logic [4:0] exp);
    logic [4:0] act;
    act = {halted_o, cause_o, priv_viol_o, resume_o};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {fault_i, bkpt_i, halt_insn_i, user_mode_i, user_halt_en_i, sample_i, go_i} = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 5'b00000);           // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][11:5]);
      @(negedge clk);
      check(int'(VEC[i][15:12]), VEC[i][4:0]);
    end
    // R1: reset during a halt
    drive(7'b1000000);
    @(negedge clk);
    check(2, 5'b10100);
    drive(7'b0000000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, 5'b00000);
    // R1: reset discards a pending request
    drive(7'b0100000);
    @(negedge clk);
    drive(7'b0000000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(7'b0000010);
    @(negedge clk);
    check(1, 5'b00000);
    // R3: pending held over several idle cycles
    drive(7'b0100000);
    @(negedge clk);
    drive(7'b0000000);
    repeat (4) @(negedge clk);
    check(3, 5'b00000);
    drive(7'b0000010);
    @(negedge clk);
    check(3, 5'b11000);
    drive(7'b0000000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule